// File: doc/BRIEF.md
# Interrupt Request Controller

This block gathers interrupt events from ten sources into sticky flag bits and decides when the instruction sequencer must enter the interrupt handler. Three sources (external pin, port change, timer0 overflow) belong to the core group. Their flags, their enables, a peripheral-group enable and the global enable share one control word. The other seven sources (comparator, ADC done, timer1 overflow, timer2 match, EEPROM write done, clock-monitor fault, capture/compare) have a flag word and an enable word of their own.

A flag latches whenever its event pulses, whatever the enables say. At each instruction-cycle boundary (strobe `icyc_i`), the block raises `take_o` for one cycle if the global enable is set and some flag is pending with its enable set. Peripheral flags also need the group enable. On `take_o` the sequencer pushes its return address and loads `vec_o`, and the block clears the global enable. A return strobe sets the global enable again. Software clears flags and changes enables through a small register port with a combinational read.

A write that clears the global enable in the same cycle as a boundary blocks entry in that cycle. The flag stays set, so the request is taken once the enable comes back.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, words 0, 1 and 2 read 0 and `take_o` stays low, even when `icyc_i` is high.
- R2: `ev_i` bit order: 0 external pin, 1 port change, 2 timer0, 3 comparator, 4 ADC, 5 timer1, 6 timer2, 7 EEPROM write, 8 clock monitor, 9 capture/compare. A pulse on bit k sets its flag on the next edge, whatever the enables or the global enable hold. Core flags k=0..2 read at address 0 bits 0..2. Peripheral flags k=3..9 read at address 1 bits 0..6.
- R3: A flag changes only through its event or a write to its word. When a write clears a flag in the same cycle as that flag's event, the flag ends up set.
- R4: `take_o` is high only in a cycle with `icyc_i` high, global enable (address 0 bit 7) set, and some pending source. A core source is pending when its flag is set and its enable (address 0 bit 3+k) is set.
- R5: A peripheral source is pending only when its flag, its enable (address 2 bit k-3) and the group enable (address 0 bit 6) are all set.
- R6: In a `take_o` cycle, `vec_o` equals 0x0004, and the global enable reads 0 from the next cycle on.
- R7: A one-cycle `rfi_i` pulse sets the global enable on the next edge.
- R8: A write to address 0 with bit 7 low suppresses `take_o` in that same cycle. The flag stays set, and entry happens at the first boundary after the global enable is set again.
- R9: A flag left set when the global enable returns causes another `take_o` at the next boundary. A flag cleared beforehand does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 10 | One-cycle event pulses, one per source |
| icyc_i | input | 1 | Instruction-cycle boundary strobe |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| wr_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register address (0 core, 1 peripheral flags, 2 peripheral enables) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| take_o | output | 1 | Interrupt entry: push return address and load vector |
| vec_o | output | 13 | Vector address |

## Verification
An event sets its flag on the clock edge that samples it, so the bench reads the flag back in the next cycle. `take_o` and `rdata_o` are combinational from registered state and the current inputs. The bench drives inputs just after a rising edge and samples them at the following falling edge, within the same cycle. The global-enable clear that follows an entry, and the set that follows a return pulse, show only one edge later, so each is read back in the cycle after its stimulus.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Register word addresses
  localparam logic [1:0] A_CORE = 2'd0;
  localparam logic [1:0] A_PFLG = 2'd1;
  localparam logic [1:0] A_PEN  = 2'd2;

  // Entry decision at a cycle boundary; a same-cycle clearing write wins.
  function automatic logic f_take(input logic icyc, input logic gie,
                                  input logic pending, input logic gie_clr);
    return icyc & gie & pending & ~gie_clr;
  endfunction

  // Next flag value: write replaces, event ORs in last so set wins.
  function automatic logic f_flag(input logic q, input logic wr,
                                  input logic wd, input logic set);
    return (wr ? wd : q) | set;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  import irq_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= f_flag(q_o[i], wr_i, wd_i[i], set_i[i]);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NCORE = 3,
  parameter int NPERI = 7
) (
  input  logic [NCORE-1:0] cflag_i,
  input  logic [NCORE-1:0] cen_i,
  input  logic [NPERI-1:0] pflag_i,
  input  logic [NPERI-1:0] pen_i,
  input  logic             peie_i,
  input  logic             gie_i,
  input  logic             icyc_i,
  input  logic             gie_clr_i,
  output logic             pend_core_o,
  output logic             pend_peri_o,
  output logic             take_o
);
  import irq_pkg::*;

  function automatic logic any_core(input logic [NCORE-1:0] f, input logic [NCORE-1:0] e);
    return |(f & e);
  endfunction

  function automatic logic any_peri(input logic [NPERI-1:0] f, input logic [NPERI-1:0] e);
    return |(f & e);
  endfunction

  assign pend_core_o = any_core(cflag_i, cen_i);
  assign pend_peri_o = peie_i & any_peri(pflag_i, pen_i);
  assign take_o      = f_take(icyc_i, gie_i, pend_core_o | pend_peri_o, gie_clr_i);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int             DW    = 8,
  parameter int             NCORE = 3,
  parameter int             NPERI = 7,
  parameter int             AW    = 2,
  parameter int             PCW   = 13,
  parameter logic [PCW-1:0] VEC   = 13'h0004
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCORE+NPERI-1:0] ev_i,
  input  logic                   icyc_i,
  input  logic                   rfi_i,
  input  logic                   wr_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   take_o,
  output logic [PCW-1:0]         vec_o
);
  import irq_pkg::*;

  localparam int NSRC   = NCORE + NPERI;
  localparam int CEN_LO = NCORE;
  localparam int PEIE_B = 2 * NCORE;
  localparam int GIE_B  = DW - 1;

  logic [NCORE-1:0] cflag, cen;
  logic [NPERI-1:0] pflag, pen;
  logic             peie, gie;
  logic             wr_core, wr_pflg, wr_pen, gie_clr_wr;
  logic             pend_core, pend_peri;
  logic [DW-1:0]    core_word;

  assign wr_core    = wr_i & (addr_i == AW'(A_CORE));
  assign wr_pflg    = wr_i & (addr_i == AW'(A_PFLG));
  assign wr_pen     = wr_i & (addr_i == AW'(A_PEN));
  assign gie_clr_wr = wr_core & ~wdata_i[GIE_B];

  irq_flag_bank #(.W(NCORE)) u_cflag (
    .clk(clk), .rst_n(rst_n), .set_i(ev_i[NCORE-1:0]),
    .wr_i(wr_core), .wd_i(wdata_i[NCORE-1:0]), .q_o(cflag));

  irq_flag_bank #(.W(NCORE)) u_cen (
    .clk(clk), .rst_n(rst_n), .set_i('0),
    .wr_i(wr_core), .wd_i(wdata_i[CEN_LO +: NCORE]), .q_o(cen));

  irq_flag_bank #(.W(1)) u_peie (
    .clk(clk), .rst_n(rst_n), .set_i(1'b0),
    .wr_i(wr_core), .wd_i(wdata_i[PEIE_B]), .q_o(peie));

  irq_flag_bank #(.W(NPERI)) u_pflag (
    .clk(clk), .rst_n(rst_n), .set_i(ev_i[NSRC-1:NCORE]),
    .wr_i(wr_pflg), .wd_i(wdata_i[NPERI-1:0]), .q_o(pflag));

  irq_flag_bank #(.W(NPERI)) u_pen (
    .clk(clk), .rst_n(rst_n), .set_i('0),
    .wr_i(wr_pen), .wd_i(wdata_i[NPERI-1:0]), .q_o(pen));

  irq_arbiter #(.NCORE(NCORE), .NPERI(NPERI)) u_arb (
    .cflag_i(cflag), .cen_i(cen), .pflag_i(pflag), .pen_i(pen),
    .peie_i(peie), .gie_i(gie), .icyc_i(icyc_i), .gie_clr_i(gie_clr_wr),
    .pend_core_o(pend_core), .pend_peri_o(pend_peri), .take_o(take_o));

  // Global enable: entry clears, return sets, software write otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie <= 1'b0;
    else if (take_o)  gie <= 1'b0;
    else if (rfi_i)   gie <= 1'b1;
    else if (wr_core) gie <= wdata_i[GIE_B];
  end

  always_comb begin
    core_word                   = '0;
    core_word[NCORE-1:0]        = cflag;
    core_word[CEN_LO +: NCORE]  = cen;
    core_word[PEIE_B]           = peie;
    core_word[GIE_B]            = gie;
  end

  always_comb begin
    case (addr_i)
      AW'(A_CORE): rdata_o = core_word;
      AW'(A_PFLG): rdata_o = DW'(pflag);
      AW'(A_PEN):  rdata_o = DW'(pen);
      default:     rdata_o = '0;
    endcase
  end

  assign vec_o = VEC;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NCORE = 3,
  parameter int NPERI = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCORE+NPERI-1:0] ev,
  input logic [NCORE-1:0]       cflag,
  input logic                   icyc,
  input logic                   rfi,
  input logic                   take,
  input logic                   gie,
  input logic                   peie,
  input logic                   pend_core,
  input logic                   wr_core,
  input logic                   gie_clr_wr
);
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n) ev[0] |=> cflag[0]); // R2
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (cflag[0] && !wr_core) |=> cflag[0]); // R3
  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n) take |-> (icyc && gie)); // R4
  AST_PERI_GROUP: assert property (@(posedge clk) disable iff (!rst_n) (take && !pend_core) |-> peie); // R5
  AST_GIE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) take |=> !gie); // R6
  AST_RFI_RAISES: assert property (@(posedge clk) disable iff (!rst_n) (rfi && !take) |=> gie); // R7
  AST_CLR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) gie_clr_wr |-> !take); // R8
endmodule

bind irq_ctrl irq_ctrl_chk #(.NCORE(NCORE), .NPERI(NPERI)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev(ev_i), .cflag(cflag), .icyc(icyc_i),
  .rfi(rfi_i), .take(take_o), .gie(gie), .peie(peie), .pend_core(pend_core),
  .wr_core(wr_core), .gie_clr_wr(gie_clr_wr));

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  ev = '0;
  logic        icyc = 1'b0, rfi = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        take;
  logic [12:0] vec;
  int nchk = 0, nfail = 0;

  irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .ev_i(ev), .icyc_i(icyc), .rfi_i(rfi),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .take_o(take), .vec_o(vec));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1; nxt(); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] v);
    addr = a; wr = 1'b0; @(negedge clk); v = rdata; nxt();
  endtask

  task automatic pulse_ev(input int s);
    ev = 10'(1 << s); nxt(); ev = '0;
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    nxt(); nxt(); rst_n = 1'b1; nxt();

    // R1: reset state
    for (int a = 0; a < 3; a++) begin rreg(2'(a), v); chk("R1 word", v, 0); end
    icyc = 1'b1; @(negedge clk); chk("R1 take", take, 0); nxt(); icyc = 1'b0;

    // R2 R4 R5 R6: sweep every source against enable, group enable and global enable
    for (int s = 0; s < 10; s++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 2; p++)
          for (int g = 0; g < 2; g++) begin
            int cen, pen, exp;
            cen = (s < 3 && e == 1) ? (1 << s) : 0;
            pen = (s >= 3 && e == 1) ? (1 << (s - 3)) : 0;
            wreg(2'd1, 8'h00);
            wreg(2'd2, 8'(pen));
            wreg(2'd0, 8'((g << 7) | (p << 6) | (cen << 3)));
            pulse_ev(s);
            if (s < 3) begin rreg(2'd0, v); chk("R2 core flag", int'(v[s]), 1); end
            else begin rreg(2'd1, v); chk("R2 peri flag", int'(v[s-3]), 1); end
            exp = (g == 1 && e == 1 && (s < 3 || p == 1)) ? 1 : 0;
            icyc = 1'b1; @(negedge clk);
            chk(s < 3 ? "R4 take" : "R5 take", take, exp);
            if (take) chk("R6 vector", vec, 4);
            nxt(); icyc = 1'b0;
            rreg(2'd0, v); chk("R6 gie after", int'(v[7]), (g == 1 && exp == 0) ? 1 : 0);
          end
    wreg(2'd0, 8'h00); wreg(2'd1, 8'h00);

    // R3: sticky flag, set wins over same-cycle clear, clear by write
    pulse_ev(1); nxt(); nxt(); nxt();
    rreg(2'd0, v); chk("R3 sticky", int'(v[1]), 1);
    ev = 10'h002; addr = 2'd0; wdata = 8'h00; wr = 1'b1; nxt(); wr = 1'b0; ev = '0;
    rreg(2'd0, v); chk("R3 set wins", int'(v[1]), 1);
    wreg(2'd0, 8'h00); rreg(2'd0, v); chk("R3 cleared", int'(v[1]), 0);

    // R4: no entry away from a cycle boundary
    wreg(2'd0, 8'h88); pulse_ev(0);
    for (int i = 0; i < 3; i++) begin @(negedge clk); chk("R4 no icyc", take, 0); nxt(); end

    // R8: clearing write suppresses the coincident boundary
    icyc = 1'b1; addr = 2'd0; wdata = 8'h09; wr = 1'b1;
    @(negedge clk); chk("R8 suppressed", take, 0);
    nxt(); icyc = 1'b0; wr = 1'b0;
    rreg(2'd0, v); chk("R8 held", v, 8'h09);
    rfi = 1'b1; @(negedge clk); chk("R8 no take w/o icyc", take, 0); nxt(); rfi = 1'b0;
    rreg(2'd0, v); chk("R7 rfi sets gie", int'(v[7]), 1);
    icyc = 1'b1; @(negedge clk); chk("R8 taken later", take, 1); nxt(); icyc = 1'b0;
    rreg(2'd0, v); chk("R6 gie cleared", int'(v[7]), 0);

    // R9: repeat while flag stays set; none after clearing it
    rfi = 1'b1; nxt(); rfi = 1'b0;
    icyc = 1'b1; @(negedge clk); chk("R9 repeat", take, 1); nxt(); icyc = 1'b0;
    wreg(2'd0, 8'h08);
    rfi = 1'b1; nxt(); rfi = 1'b0;
    icyc = 1'b1; @(negedge clk); chk("R9 cleared no repeat", take, 0); nxt(); icyc = 1'b0;
    rreg(2'd0, v); chk("R7 gie set", int'(v[7]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule